// File: doc/BRIEF.md
# Windowed Mismatch Accumulator and Flow Update Unit

This unit carries out one refinement step of a gradient-based motion estimator for a single pixel. A window of samples streams in, one per cycle. Each sample carries the two spatial gradients of the first image, the luminance of the first image at the window point, and the luminance of the second image at the point moved by the current flow guess. For each sample the unit forms a filtered temporal difference. It multiplies that difference by both gradients and sums the two products over the window.

When the last sample of a window arrives, the unit also captures the side-band operands. These are the 2x2 gradient matrix, the prior flow guess, a flag that says whether the prior comes from the next coarser pyramid level, and the search limit. The unit then solves the 2x2 system through the determinant and the adjugate. Two sequential restoring dividers, one per axis, do the division. The unit adds the resulting increment to the prior flow, which is doubled when it comes from a coarser level. It clamps the sum to the search limit and presents the result with a one-cycle strobe.

Flow values are signed fixed point with two fractional bits. A caller that walks a pyramid from coarse to fine feeds each result back as the next prior and raises the level flag. The samples of the next window may already stream in while a solve is under way.

Top module: `flow_update_unit`

## Requirements
- R1: After reset, `out_valid` is low and both flow outputs are zero.
- R2: Each sample's temporal term is floor(3·(a − b)/4), where a is the first-image luminance and b is the displaced second-image luminance. The unit forms it as (d + 2d) shifted right arithmetically by two, so negative odd differences round toward minus infinity.
- R3: The mismatch sums are Sx = Σ ix·t and Sy = Σ iy·t, taken over every valid sample from the first one after the previous window's last sample up to and including the sample with `s_last` high.
- R4: With det = gxx·gyy − gxy², the raw increments are 4·(gyy·Sx − gxy·Sy)/det and 4·(gxx·Sy − gxy·Sx)/det. The division truncates toward zero, so the result is in quarter-pixel units.
- R5: When det ≤ DET_MIN (default 16), both increments are zero and the output equals the clamped prior flow.
- R6: The prior flow is used as given when `lvl_down` is 0 and doubled when `lvl_down` is 1.
- R7: Each output component is min(max(base + increment, −limit), +limit). The bound is inclusive.
- R8: `out_valid` is high for exactly one cycle per window. The flow outputs hold their value until the next strobe.
- R9: The gradient matrix, prior flow, level flag and limit are taken only in the cycle where `s_valid` and `s_last` are both high. Later changes to them do not affect that window's result.
- R10: Cycles with `s_valid` low add nothing to the sums, whatever values the data inputs carry.
- R11: Non-last samples of the next window may arrive while a solve is under way, and they are kept for that window. A last sample may arrive only once the previous result has been strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Window sample present |
| s_last | input | 1 | Final sample of the window; side-band operands sampled |
| s_ix | input | GRW | Signed horizontal gradient |
| s_iy | input | GRW | Signed vertical gradient |
| s_ia | input | PW | First-image luminance, unsigned |
| s_jb | input | PW | Displaced second-image luminance, unsigned |
| g_xx | input | GW | Signed gradient matrix element Σix² |
| g_xy | input | GW | Signed gradient matrix element Σix·iy |
| g_yy | input | GW | Signed gradient matrix element Σiy² |
| prior_x | input | FW | Signed prior horizontal flow, 2 fractional bits |
| prior_y | input | FW | Signed prior vertical flow, 2 fractional bits |
| lvl_down | input | 1 | Prior comes from the coarser level; double it |
| limit | input | FW-1 | Unsigned search bound, 2 fractional bits |
| out_valid | output | 1 | One-cycle result strobe |
| flow_x | output | FW | Updated horizontal flow |
| flow_y | output | FW | Updated vertical flow |

## Verification
The assertions take for granted that a window ends only while the unit is idle. No `s_last` may arrive during a solve, or in the cycle the summed window hands over to it. The stimulus meets this by holding every last sample back until the previous strobe has been seen. Samples that are not last may still overlap a solve.

The assertions also assume the window sums stay inside the accumulator width. The directed windows therefore use short windows with moderate gradients. The gradient matrices are positive semidefinite, so their determinants are never negative.

// File: rtl/fu_pkg.sv
package fu_pkg;
    localparam int PIX_W  = 8;
    localparam int GRD_W  = 10;
    localparam int SUM_W  = 24;
    localparam int GMAT_W = 24;
    localparam int FLOW_W = 12;
    localparam int DET_FLOOR = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIV,
        ST_FIN
    } fu_state_e;
endpackage

// File: rtl/fu_mmv_accum.sv
module fu_mmv_accum #(
    parameter int PW  = 8,
    parameter int GRW = 10,
    parameter int BW  = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  s_valid,
    input  logic                  s_last,
    input  logic signed [GRW-1:0] s_ix,
    input  logic signed [GRW-1:0] s_iy,
    input  logic [PW-1:0]         s_ia,
    input  logic [PW-1:0]         s_jb,
    output logic                  done,
    output logic signed [BW-1:0]  bx,
    output logic signed [BW-1:0]  by
);
    localparam int DFW = PW + 1;
    localparam int TW  = PW + 3;
    localparam int PDW = GRW + DFW;

    logic signed [DFW-1:0] diff;
    logic signed [TW-1:0]  tri3;
    logic signed [DFW-1:0] tdel;
    logic signed [PDW-1:0] prod_x, prod_y;
    logic signed [BW-1:0]  acc_x, acc_y, nxt_x, nxt_y;

    always_comb begin
        diff   = $signed({1'b0, s_ia}) - $signed({1'b0, s_jb});
        tri3   = TW'(diff) + (TW'(diff) <<< 1);
        tdel   = DFW'(tri3 >>> 2);
        prod_x = PDW'(s_ix) * PDW'(tdel);
        prod_y = PDW'(s_iy) * PDW'(tdel);
        nxt_x  = acc_x + BW'(prod_x);
        nxt_y  = acc_y + BW'(prod_y);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_x <= '0;
            acc_y <= '0;
            bx    <= '0;
            by    <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (s_valid) begin
                if (s_last) begin
                    bx    <= nxt_x;
                    by    <= nxt_y;
                    acc_x <= '0;
                    acc_y <= '0;
                    done  <= 1'b1;
                end else begin
                    acc_x <= nxt_x;
                    acc_y <= nxt_y;
                end
            end
        end
    end
endmodule

// File: rtl/fu_divider.sv
module fu_divider #(
    parameter int DW = 51
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] quotient
);
    localparam int CW = $clog2(DW + 1);
    localparam int XW = 2 * DW + 1;

    logic [DW-1:0] rem_q, quo_q, dvd_q, den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [DW:0]   shf, dif;

    always_comb begin
        shf = {rem_q, quo_q[DW-1]};
        dif = shf - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dvd_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo_q <= dividend;
                dvd_q <= dividend;
                den_q <= divisor;
                cnt_q <= CW'(DW);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!dif[DW]) begin
                    rem_q <= dif[DW-1:0];
                    quo_q <= {quo_q[DW-2:0], 1'b1};
                end else begin
                    rem_q <= shf[DW-1:0];
                    quo_q <= {quo_q[DW-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

    logic [XW-1:0] recon;
    always_comb recon = XW'(quo_q) * XW'(den_q) + XW'(rem_q);

    // R4: a finished division reconstructs its dividend with a proper remainder
    a_r4_div_identity: assert property (@(posedge clk) disable iff (rst)
        done |-> (recon == XW'(dvd_q)) && (rem_q < den_q));
endmodule

// File: rtl/flow_update_unit.sv
module flow_update_unit
    import fu_pkg::*;
#(
    parameter int PW      = PIX_W,
    parameter int GRW     = GRD_W,
    parameter int BW      = SUM_W,
    parameter int GW      = GMAT_W,
    parameter int FW      = FLOW_W,
    parameter int DET_MIN = DET_FLOOR
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  s_valid,
    input  logic                  s_last,
    input  logic signed [GRW-1:0] s_ix,
    input  logic signed [GRW-1:0] s_iy,
    input  logic [PW-1:0]         s_ia,
    input  logic [PW-1:0]         s_jb,
    input  logic signed [GW-1:0]  g_xx,
    input  logic signed [GW-1:0]  g_xy,
    input  logic signed [GW-1:0]  g_yy,
    input  logic signed [FW-1:0]  prior_x,
    input  logic signed [FW-1:0]  prior_y,
    input  logic                  lvl_down,
    input  logic [FW-2:0]         limit,
    output logic                  out_valid,
    output logic signed [FW-1:0]  flow_x,
    output logic signed [FW-1:0]  flow_y
);
    localparam int DTW = 2 * GW + 1;
    localparam int PRW = GW + BW + 1;
    localparam int NW  = PRW + 2;
    localparam int XW  = FW + 3;
    localparam logic [NW-1:0] QLIM = NW'(2 ** (FW + 1));

    // side-band operands captured with the last sample
    logic signed [GW-1:0] gxx_q, gxy_q, gyy_q;
    logic signed [FW-1:0] pr_q [2];
    logic                 lvl_q;
    logic [FW-2:0]        lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gxx_q <= '0;
            gxy_q <= '0;
            gyy_q <= '0;
            pr_q  <= '{default: '0};
            lvl_q <= 1'b0;
            lim_q <= '0;
        end else if (s_valid && s_last) begin
            gxx_q <= g_xx;
            gxy_q <= g_xy;
            gyy_q <= g_yy;
            pr_q  <= '{prior_x, prior_y};
            lvl_q <= lvl_down;
            lim_q <= limit;
        end
    end

    logic                 acc_done;
    logic signed [BW-1:0] sum_x, sum_y;

    fu_mmv_accum #(.PW(PW), .GRW(GRW), .BW(BW)) u_acc (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_last(s_last),
        .s_ix(s_ix), .s_iy(s_iy), .s_ia(s_ia), .s_jb(s_jb),
        .done(acc_done), .bx(sum_x), .by(sum_y)
    );

    // determinant and adjugate products
    logic signed [DTW-1:0] det;
    logic signed [PRW-1:0] num [2];
    logic signed [NW-1:0]  num4 [2];
    logic [NW-1:0]         mag_w [2];
    logic                  det_small;

    always_comb begin
        det       = DTW'(gxx_q) * DTW'(gyy_q) - DTW'(gxy_q) * DTW'(gxy_q);
        num[0]    = PRW'(gyy_q) * PRW'(sum_x) - PRW'(gxy_q) * PRW'(sum_y);
        num[1]    = PRW'(gxx_q) * PRW'(sum_y) - PRW'(gxy_q) * PRW'(sum_x);
        det_small = det <= $signed(DTW'(DET_MIN));
        for (int a = 0; a < 2; a++) begin
            num4[a]  = {num[a], 2'b00};
            mag_w[a] = num4[a][NW-1] ? NW'(-num4[a]) : NW'(num4[a]);
        end
    end

    fu_state_e     st;
    logic          div_go, zero_q;
    logic [NW-1:0] mag_q [2];
    logic          neg_q [2];
    logic [NW-1:0] den_q;
    logic [1:0]    dv_done;
    logic [NW-1:0] quo [2];

    for (genvar ax = 0; ax < 2; ax++) begin : g_axis
        fu_divider #(.DW(NW)) u_div (
            .clk(clk), .rst(rst), .go(div_go),
            .dividend(mag_q[ax]), .divisor(den_q),
            .done(dv_done[ax]), .quotient(quo[ax])
        );
    end

    // increment, base scaling and clamp
    logic signed [XW-1:0] lim_s;
    logic signed [XW-1:0] base [2];
    logic signed [XW-1:0] incr [2];
    logic signed [XW-1:0] total [2];
    logic signed [FW-1:0] res_w [2];
    logic [NW-1:0]        qsat;

    always_comb begin
        lim_s = $signed(XW'(lim_q));
        qsat  = '0;
        for (int a = 0; a < 2; a++) begin
            qsat    = (quo[a] > QLIM) ? QLIM : quo[a];
            base[a] = lvl_q ? (XW'(pr_q[a]) <<< 1) : XW'(pr_q[a]);
            if (zero_q)
                incr[a] = '0;
            else if (neg_q[a])
                incr[a] = -$signed(XW'(qsat));
            else
                incr[a] = $signed(XW'(qsat));
            total[a] = base[a] + incr[a];
            if (total[a] > lim_s)
                res_w[a] = FW'(lim_s);
            else if (total[a] < -lim_s)
                res_w[a] = FW'(-lim_s);
            else
                res_w[a] = FW'(total[a]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            div_go    <= 1'b0;
            zero_q    <= 1'b0;
            mag_q     <= '{default: '0};
            neg_q     <= '{default: 1'b0};
            den_q     <= '0;
            out_valid <= 1'b0;
            flow_x    <= '0;
            flow_y    <= '0;
        end else begin
            div_go    <= 1'b0;
            out_valid <= 1'b0;
            case (st)
                ST_IDLE: if (acc_done) begin
                    mag_q  <= mag_w;
                    neg_q  <= '{num4[0][NW-1], num4[1][NW-1]};
                    den_q  <= NW'($unsigned(det));
                    zero_q <= det_small;
                    if (det_small) begin
                        st <= ST_FIN;
                    end else begin
                        div_go <= 1'b1;
                        st     <= ST_DIV;
                    end
                end
                ST_DIV: if (&dv_done) st <= ST_FIN;
                ST_FIN: begin
                    flow_x    <= res_w[0];
                    flow_y    <= res_w[1];
                    out_valid <= 1'b1;
                    st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R7: strobed flow never leaves the captured search bound
    a_r7_within_limit: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (XW'(flow_x) <= lim_s) && (XW'(flow_x) >= -lim_s)
                   && (XW'(flow_y) <= lim_s) && (XW'(flow_y) >= -lim_s));

    // R8: the strobe lasts one cycle and the result then holds
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid && $stable(flow_x) && $stable(flow_y));

    // R11: a window may close only while no solve is pending
    a_r11_last_when_idle: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_last) |-> (st == ST_IDLE) && !acc_done);

    // R5: a small determinant skips the dividers entirely
    a_r5_skip_divider: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FIN) && zero_q |-> !(|dv_done));
endmodule

// File: tb/flow_update_unit_test.sv
module flow_update_unit_test;
    localparam int FW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic s_valid = 1'b0, s_last = 1'b0;
    logic signed [9:0] s_ix = '0, s_iy = '0;
    logic [7:0] s_ia = '0, s_jb = '0;
    logic signed [23:0] g_xx = '0, g_xy = '0, g_yy = '0;
    logic signed [FW-1:0] prior_x = '0, prior_y = '0;
    logic lvl_down = 1'b0;
    logic [FW-2:0] limit = '0;
    logic out_valid;
    logic signed [FW-1:0] flow_x, flow_y;

    always #4 clk = ~clk;

    flow_update_unit uut (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_last(s_last),
        .s_ix(s_ix), .s_iy(s_iy), .s_ia(s_ia), .s_jb(s_jb),
        .g_xx(g_xx), .g_xy(g_xy), .g_yy(g_yy),
        .prior_x(prior_x), .prior_y(prior_y), .lvl_down(lvl_down),
        .limit(limit), .out_valid(out_valid), .flow_x(flow_x), .flow_y(flow_y)
    );

    typedef struct {
        longint gxx, gxy, gyy;
        int     px, py;
        bit     lvl;
        int     lim;
    } side_t;

    int vx [16], vy [16], va [16], vb [16];
    int total = 0, bad = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampv(longint v, int lim);
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return int'(v);
    endfunction

    function automatic void model(int first, int cnt, side_t sd, output int ex, output int ey);
        longint sx = 0, sy = 0, det, ix, iy, bxs, bys;
        for (int i = first; i < first + cnt; i++) begin
            int d = va[i] - vb[i];
            int t = (3 * d) >>> 2;
            sx += longint'(vx[i]) * t;
            sy += longint'(vy[i]) * t;
        end
        det = sd.gxx * sd.gyy - sd.gxy * sd.gxy;
        if (det <= 16) begin
            ix = 0;
            iy = 0;
        end else begin
            ix = (4 * (sd.gyy * sx - sd.gxy * sy)) / det;
            iy = (4 * (sd.gxx * sy - sd.gxy * sx)) / det;
        end
        bxs = sd.lvl ? 2 * sd.px : sd.px;
        bys = sd.lvl ? 2 * sd.py : sd.py;
        ex = clampv(bxs + ix, sd.lim);
        ey = clampv(bys + iy, sd.lim);
    endfunction

    task automatic put_side(side_t sd);
        g_xx = 24'(sd.gxx); g_xy = 24'(sd.gxy); g_yy = 24'(sd.gyy);
        prior_x = FW'(sd.px); prior_y = FW'(sd.py);
        lvl_down = sd.lvl; limit = (FW-1)'(sd.lim);
    endtask

    task automatic scramble_side();
        g_xx = 24'd999; g_xy = -24'sd77; g_yy = 24'd5;
        prior_x = 12'sd300; prior_y = -12'sd300;
        lvl_down = ~lvl_down; limit = 11'd1;
    endtask

    // drives samples [first, first+cnt); the final one carries s_last when close=1
    task automatic feed(int first, int cnt, bit close, side_t sd, bit gaps);
        for (int i = first; i < first + cnt; i++) begin
            if (gaps) begin
                @(negedge clk);
                s_valid = 1'b0; s_last = 1'b1;
                s_ix = 10'sd200; s_iy = -10'sd150; s_ia = 8'd255; s_jb = 8'd0;
            end
            @(negedge clk);
            s_valid = 1'b1;
            s_last  = close && (i == first + cnt - 1);
            s_ix = 10'(vx[i]); s_iy = 10'(vy[i]);
            s_ia = 8'(va[i]);  s_jb = 8'(vb[i]);
            if (s_last) put_side(sd);
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic await_check(string req, int ex, int ey);
        int n = 0;
        while (!out_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        check({req, " strobe"}, out_valid, 1);
        check({req, " flow_x"}, flow_x, ex);
        check({req, " flow_y"}, flow_y, ey);
        @(negedge clk);
        check("R8 strobe drops", out_valid, 0);
        check("R8 x held", flow_x, ex);
        check("R8 y held", flow_y, ey);
    endtask

    task automatic run(string req, int first, int cnt, side_t sd, bit gaps, bit scr);
        int ex, ey;
        model(first, cnt, sd, ex, ey);
        feed(first, cnt, 1'b1, sd, gaps);
        if (scr) scramble_side();
        await_check(req, ex, ey);
    endtask

    task automatic load(int i, int x, int y, int a, int b);
        vx[i] = x; vy[i] = y; va[i] = a; vb[i] = b;
    endtask

    task automatic t_reset();
        check("R1 strobe low", out_valid, 0);
        check("R1 x zero", flow_x, 0);
        check("R1 y zero", flow_y, 0);
    endtask

    task automatic t_basic();
        side_t sd = '{gxx: 900, gxy: 120, gyy: 700, px: 6, py: -3, lvl: 0, lim: 200};
        load(0, 30, 10, 120, 100); load(1, -12, 25, 90, 95);
        load(2, 8, -20, 60, 61);   load(3, 40, 3, 200, 180);
        load(4, -5, -7, 10, 40);   load(5, 17, 22, 77, 70);
        run("R3 R4 solve", 0, 6, sd, 0, 0);
    endtask

    task automatic t_floor();
        side_t sd = '{gxx: 8, gxy: 0, gyy: 8, px: 0, py: 0, lvl: 0, lim: 100};
        load(0, 8, 4, 10, 13);
        run("R2 floor of negative odd", 0, 1, sd, 0, 0);
    endtask

    task automatic t_gaps();
        side_t sd = '{gxx: 400, gxy: -50, gyy: 350, px: -2, py: 9, lvl: 0, lim: 300};
        load(0, 20, -15, 150, 140); load(1, -9, 11, 33, 50);
        load(2, 14, 6, 80, 71);     load(3, 3, -30, 120, 126);
        run("R10 idle cycles ignored", 0, 4, sd, 1, 0);
    endtask

    task automatic t_singular();
        side_t sd = '{gxx: 4, gxy: 4, gyy: 4, px: 5, py: -7, lvl: 0, lim: 100};
        side_t sb = '{gxx: 4, gxy: 0, gyy: 4, px: -9, py: 11, lvl: 1, lim: 100};
        side_t sc = '{gxx: 17, gxy: 0, gyy: 1, px: 0, py: 0, lvl: 0, lim: 500};
        load(0, 50, 40, 200, 100);
        run("R5 zero determinant", 0, 1, sd, 0, 0);
        run("R5 determinant at floor", 0, 1, sb, 0, 0);
        load(1, 2, 1, 20, 0);
        run("R5 determinant above floor", 1, 1, sc, 0, 0);
    endtask

    task automatic t_level();
        side_t sd = '{gxx: 600, gxy: 40, gyy: 500, px: 13, py: -21, lvl: 1, lim: 400};
        load(0, 10, 12, 100, 96); load(1, -6, 8, 70, 74); load(2, 9, -4, 55, 50);
        run("R6 doubled prior", 0, 3, sd, 0, 0);
    endtask

    task automatic t_clamp();
        side_t sp = '{gxx: 20, gxy: 0, gyy: 20, px: 30, py: -30, lvl: 0, lim: 40};
        side_t se = '{gxx: 1000, gxy: 0, gyy: 1000, px: 40, py: -40, lvl: 0, lim: 40};
        load(0, 60, -60, 250, 10); load(1, 50, -50, 240, 20);
        run("R7 clamp both signs", 0, 2, sp, 0, 0);
        load(2, 0, 0, 0, 0);
        run("R7 exact bound kept", 2, 1, se, 0, 0);
    endtask

    task automatic t_side();
        side_t sd = '{gxx: 300, gxy: 25, gyy: 280, px: -4, py: 7, lvl: 0, lim: 250};
        load(0, 11, -13, 140, 120); load(1, 7, 19, 60, 75);
        run("R9 side sampled on last", 0, 2, sd, 0, 1);
    endtask

    task automatic t_overlap();
        side_t sa = '{gxx: 500, gxy: 10, gyy: 450, px: 3, py: 2, lvl: 0, lim: 300};
        side_t sb = '{gxx: 350, gxy: -30, gyy: 420, px: -8, py: 5, lvl: 1, lim: 300};
        int ax, ay, bx, by;
        load(0, 12, 9, 110, 100); load(1, -7, 14, 40, 52);
        load(2, 15, -6, 90, 70);  load(3, 9, 9, 30, 44); load(4, -11, 4, 66, 60);
        model(0, 2, sa, ax, ay);
        model(2, 3, sb, bx, by);
        feed(0, 2, 1'b1, sa, 0);
        feed(2, 2, 1'b0, sb, 0);
        await_check("R11 first window", ax, ay);
        feed(4, 1, 1'b1, sb, 0);
        await_check("R11 overlapped window", bx, by);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_basic();
        t_floor();
        t_gaps();
        t_singular();
        t_level();
        t_clamp();
        t_side();
        t_overlap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule